// File: doc/BRIEF.md
# Free-Running Timer with Two Compare Channels

This block is a 16-bit up-counter that advances by one on each cycle in which the tick-enable input is high. Two compare values, A and B, are checked against the counter on every tick. A match sets a sticky flag for that channel. Channel A can also restart the count: when its clear control is set, a match loads zero and the increment of that same tick is then applied. When the count rolls over from all ones to zero, a third sticky flag records the rollover.

Each of the three flags has its own enable bit. A single level interrupt request stays high while any enabled flag is pending. A vector output names the most urgent pending source: rollover first, then channel B, then channel A.

Software reaches the counter, both compare values, the status/control word and the enable word through a simple register port. The port has a one-cycle write strobe and a combinational read.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset the counter reads 0, both compare registers read 16'hFFFF, the status word (address 3) and the enable word (address 4) read 0, `irq` is 0 and `irq_vec` is 0.
- R2: Each clock cycle with `tick_en` high and no software write to the counter (address 0) raises the counter by one. A cycle with `tick_en` low leaves it unchanged.
- R3: On a tick where the counter equals compare A (address 1), status bit 0 becomes 1.
- R4: On a tick where the counter equals compare A and status bit 8 (clear-on-A) is 1, the counter is zeroed and then incremented, so it reads 1 after that tick. Because of this, the tick does not count as a rollover.
- R5: On a tick where the counter equals compare B (address 2), status bit 1 becomes 1. A B match never alters the count sequence.
- R6: A tick that advances the counter from 16'hFFFF to 0 sets status bit 2.
- R7: Status bits 0 to 2 are sticky. Writing the status word clears each flag whose written bit is 0 and keeps each flag whose written bit is 1. A hardware set in the same cycle wins over a clear. The write also loads bit 8 from the written data.
- R8: The enable word (address 4) gates the flags: bit 0 gates A, bit 1 gates B and bit 2 gates rollover. `irq` is 1 exactly when some flag and its enable are both 1.
- R9: `irq_vec` is 18 when rollover is pending and enabled. Otherwise it is 17 when B is pending and enabled, otherwise 16 for A, and 0 when nothing is pending.
- R10: Writes to the counter and to the compare registers take effect on the next clock edge and read back unchanged. A counter write overrides a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count-advance enable, one step per high cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: 0 counter, 1 compare A, 2 compare B, 3 status/control, 4 enable |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the addressed register (combinational) |
| irq | output | 1 | Level interrupt request |
| irq_vec | output | 5 | Vector of the highest-priority pending enabled source, 0 if none |

## Verification
A table of scenarios sets compare values, the clear control and a start count, then runs a fixed number of ticks. Each scenario then checks the final count and status word. The scenarios are chosen so that each can only pass if the design gets one case right:
- A lone A match without clearing.
- An A match with clearing, which shows the count restarts at 1.
- A rollover followed by a B match.
- A and B matching on the same tick.
- A B match with the clear control set, which shows B never clears.
- An A match at all ones with clearing, which shows the clear suppresses the rollover flag.

Directed tests then cover the remaining behaviour:
- A write that clears the flags landing in the same cycle as a match.
- Keep-on-one versus clear-on-zero status writes.
- Stepping through each source and several enable masks, which separates the priority order from the enable gating.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned NSRC     = 3;
  localparam int unsigned SRC_A    = 0;
  localparam int unsigned SRC_B    = 1;
  localparam int unsigned SRC_WRAP = 2;
  localparam int unsigned CLR_BIT  = 8;

  typedef enum logic [2:0] {
    ADDR_COUNT = 3'd0,
    ADDR_CMPA  = 3'd1,
    ADDR_CMPB  = 3'd2,
    ADDR_STAT  = 3'd3,
    ADDR_IEN   = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick,
  input  logic                       cnt_wr,
  input  logic [W-1:0]               wdata,
  input  logic [W-1:0]               cmp_a,
  input  logic [W-1:0]               cmp_b,
  input  logic                       clr_on_a,
  output logic [W-1:0]               cnt_q,
  output logic [tmr_pkg::NSRC-1:0]   hit
);
  import tmr_pkg::*;

  logic         match_a, match_b, wrapped;
  logic [W-1:0] base, stepped, cnt_d;

  always_comb begin
    match_a = (cnt_q == cmp_a);
    match_b = (cnt_q == cmp_b);
    base    = (match_a && clr_on_a) ? '0 : cnt_q;
    stepped = base + W'(1);
    wrapped = (stepped == '0);
    hit           = '0;
    hit[SRC_A]    = tick && match_a;
    hit[SRC_B]    = tick && match_b;
    hit[SRC_WRAP] = tick && wrapped;
    if (cnt_wr)    cnt_d = wdata;
    else if (tick) cnt_d = stepped;
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      stat_wr,
  input  logic [tmr_pkg::NSRC-1:0]  keep_mask,
  input  logic                      clr_wdata,
  input  logic [tmr_pkg::NSRC-1:0]  hit,
  output logic [tmr_pkg::NSRC-1:0]  flags_q,
  output logic                      clr_on_a_q
);
  import tmr_pkg::*;

  logic [NSRC-1:0] flags_d;
  logic            clr_d;

  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    always_comb begin
      flags_d[i] = hit[i] | (flags_q[i] & ~(stat_wr & ~keep_mask[i]));
    end
  end

  always_comb begin
    clr_d = stat_wr ? clr_wdata : clr_on_a_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q    <= '0;
      clr_on_a_q <= 1'b0;
    end else begin
      flags_q    <= flags_d;
      clr_on_a_q <= clr_d;
    end
  end
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
  parameter int unsigned VEC_W    = 5,
  parameter int unsigned VEC_BASE = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ien_wr,
  input  logic [tmr_pkg::NSRC-1:0]  ien_wdata,
  input  logic [tmr_pkg::NSRC-1:0]  flags,
  output logic [tmr_pkg::NSRC-1:0]  ien_q,
  output logic                      irq,
  output logic [VEC_W-1:0]          irq_vec
);
  import tmr_pkg::*;

  logic [NSRC-1:0] ien_d, pend;

  always_comb begin
    ien_d   = ien_wr ? ien_wdata : ien_q;
    pend    = flags & ien_q;
    irq     = |pend;
    irq_vec = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (pend[i]) irq_vec = VEC_W'(VEC_BASE + i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ien_q <= '0;
    else        ien_q <= ien_d;
  end
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer #(
  parameter int unsigned W        = 16,
  parameter int unsigned AW       = 3,
  parameter int unsigned VEC_W    = 5,
  parameter int unsigned VEC_BASE = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [W-1:0]     reg_wdata,
  output logic [W-1:0]     reg_rdata,
  output logic             irq,
  output logic [VEC_W-1:0] irq_vec
);
  import tmr_pkg::*;

  localparam int unsigned NCMP = 2;

  logic [W-1:0]    cnt_q;
  logic [W-1:0]    cmp_q [NCMP];
  logic [W-1:0]    cmp_d [NCMP];
  logic [NCMP-1:0] cmp_wr;
  logic [W-1:0]    cmp_a, cmp_b;
  logic [NSRC-1:0] hit, flags, ien;
  logic            clr_on_a;
  logic            cnt_wr, stat_wr, ien_wr;

  always_comb begin
    cnt_wr    = reg_wr && (reg_addr == AW'(ADDR_COUNT));
    stat_wr   = reg_wr && (reg_addr == AW'(ADDR_STAT));
    ien_wr    = reg_wr && (reg_addr == AW'(ADDR_IEN));
    cmp_wr[0] = reg_wr && (reg_addr == AW'(ADDR_CMPA));
    cmp_wr[1] = reg_wr && (reg_addr == AW'(ADDR_CMPB));
  end

  for (genvar c = 0; c < NCMP; c++) begin : g_cmp
    always_comb begin
      cmp_d[c] = cmp_wr[c] ? reg_wdata : cmp_q[c];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmp_q[c] <= '1;
      else        cmp_q[c] <= cmp_d[c];
    end
  end

  assign cmp_a = cmp_q[0];
  assign cmp_b = cmp_q[1];

  tmr_counter #(.W(W)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_en),
    .cnt_wr   (cnt_wr),
    .wdata    (reg_wdata),
    .cmp_a    (cmp_a),
    .cmp_b    (cmp_b),
    .clr_on_a (clr_on_a),
    .cnt_q    (cnt_q),
    .hit      (hit)
  );

  tmr_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .stat_wr    (stat_wr),
    .keep_mask  (reg_wdata[NSRC-1:0]),
    .clr_wdata  (reg_wdata[CLR_BIT]),
    .hit        (hit),
    .flags_q    (flags),
    .clr_on_a_q (clr_on_a)
  );

  tmr_irq #(.VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ien_wr    (ien_wr),
    .ien_wdata (reg_wdata[NSRC-1:0]),
    .flags     (flags),
    .ien_q     (ien),
    .irq       (irq),
    .irq_vec   (irq_vec)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      AW'(ADDR_COUNT): reg_rdata = cnt_q;
      AW'(ADDR_CMPA):  reg_rdata = cmp_a;
      AW'(ADDR_CMPB):  reg_rdata = cmp_b;
      AW'(ADDR_STAT): begin
        reg_rdata[NSRC-1:0] = flags;
        reg_rdata[CLR_BIT]  = clr_on_a;
      end
      AW'(ADDR_IEN):   reg_rdata[NSRC-1:0] = ien;
      default:         reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int unsigned W     = 16,
  parameter int unsigned VEC_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             cnt_wr,
  input logic [W-1:0]     cnt,
  input logic [W-1:0]     cmp_a,
  input logic [W-1:0]     cmp_b,
  input logic             clr_on_a,
  input logic [2:0]       flags,
  input logic             irq,
  input logic [VEC_W-1:0] irq_vec
);
  logic a_clear;
  assign a_clear = (cnt == cmp_a) && clr_on_a;

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !cnt_wr && !a_clear) |=> (cnt == W'($past(cnt) + 1'b1)));

  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !cnt_wr) |=> $stable(cnt));

  assert_flag_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && (cnt == cmp_a)) |=> flags[0]);

  assert_clear_on_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !cnt_wr && a_clear) |=> (cnt == W'(1)));

  assert_flag_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && (cnt == cmp_b)) |=> flags[1]);

  assert_wrap_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !a_clear && (cnt == '1)) |=> flags[2]);

  assert_vec_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_vec >= VEC_W'(16) && irq_vec <= VEC_W'(18)));

  assert_vec_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> (irq_vec == '0));
endmodule

bind dual_cmp_timer tmr_checker #(.W(W), .VEC_W(VEC_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_en  (tick_en),
  .cnt_wr   (cnt_wr),
  .cnt      (cnt_q),
  .cmp_a    (cmp_a),
  .cmp_b    (cmp_b),
  .clr_on_a (clr_on_a),
  .flags    (flags),
  .irq      (irq),
  .irq_vec  (irq_vec)
);

// File: tb/dual_cmp_timer_bench.sv
module dual_cmp_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;

  logic        clk, rst_n, tick_en, reg_wr;
  logic [2:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic        irq;
  logic [4:0]  irq_vec;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // cmp_a, cmp_b, clr, start, ticks, exp_cnt, exp_status
  typedef struct packed {
    logic [15:0] ca, cb;
    logic        clr;
    logic [15:0] start;
    logic [7:0]  nt;
    logic [15:0] ecnt, estat;
  } vec_t;

  localparam vec_t VT [NVEC] = '{
    '{16'h0010, 16'h0020, 1'b0, 16'h000E, 8'd4, 16'h0012, 16'h0001},
    '{16'h0005, 16'hFFFF, 1'b1, 16'h0003, 8'd4, 16'h0002, 16'h0101},
    '{16'h1234, 16'h0001, 1'b0, 16'hFFFE, 8'd4, 16'h0002, 16'h0006},
    '{16'h0040, 16'h0040, 1'b1, 16'h003F, 8'd2, 16'h0001, 16'h0103},
    '{16'h0100, 16'h0050, 1'b1, 16'h004F, 8'd3, 16'h0052, 16'h0102},
    '{16'hFFFF, 16'h0000, 1'b1, 16'hFFFE, 8'd2, 16'h0001, 16'h0101}
  };

  dual_cmp_timer u_dual_cmp_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .irq_vec(irq_vec)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] v;
    rst_n = 1'b0; tick_en = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, v); check("R1 counter", v, 16'h0000);
    rd(3'd1, v); check("R1 cmpA", v, 16'hFFFF);
    rd(3'd2, v); check("R1 cmpB", v, 16'hFFFF);
    rd(3'd3, v); check("R1 status", v, 16'h0000);
    rd(3'd4, v); check("R1 enable", v, 16'h0000);
    check("R1 irq", {15'd0, irq}, 16'd0);
    check("R1 vec", {11'd0, irq_vec}, 16'd0);

    // R2 basic stepping and hold
    ticks(5);
    rd(3'd0, v); check("R2 five ticks", v, 16'h0005);
    repeat (4) @(negedge clk);
    rd(3'd0, v); check("R2 hold without tick", v, 16'h0005);

    // Table of scenarios: R3 R4 R5 R6
    for (int i = 0; i < NVEC; i++) begin
      wr(3'd1, VT[i].ca);
      wr(3'd2, VT[i].cb);
      wr(3'd0, VT[i].start);
      wr(3'd3, {7'd0, VT[i].clr, 8'd0});
      ticks(int'(VT[i].nt));
      rd(3'd0, v); check($sformatf("R3/R4/R5/R6 vec%0d count", i), v, VT[i].ecnt);
      rd(3'd3, v); check($sformatf("R3/R4/R5/R6 vec%0d status", i), v, VT[i].estat);
    end

    // R10 readback of programmed values
    wr(3'd1, 16'hA5C3); rd(3'd1, v); check("R10 cmpA readback", v, 16'hA5C3);
    wr(3'd2, 16'h3C5A); rd(3'd2, v); check("R10 cmpB readback", v, 16'h3C5A);
    // R10 counter write wins over tick in same cycle
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 16'h0777; tick_en = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; tick_en = 1'b0;
    rd(3'd0, v); check("R10 write over tick", v, 16'h0777);

    // R7 sticky flags: keep-on-one, clear-on-zero
    wr(3'd3, 16'h0000);
    wr(3'd1, 16'h0200); wr(3'd2, 16'h0201); wr(3'd0, 16'h0200);
    ticks(2);
    rd(3'd3, v); check("R7 flags set", v, 16'h0003);
    ticks(3);
    rd(3'd3, v); check("R7 flags sticky", v, 16'h0003);
    wr(3'd3, 16'h0002);
    rd(3'd3, v); check("R7 keep bit1 clear bit0", v, 16'h0002);
    wr(3'd3, 16'h0000);
    rd(3'd3, v); check("R7 clear all", v, 16'h0000);
    // R7 hardware set beats clear in same cycle
    wr(3'd0, 16'h0200);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = 16'h0000; tick_en = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; tick_en = 1'b0;
    rd(3'd3, v); check("R7 set wins over clear", v, 16'h0001);

    // R8 R9 enables and priority
    wr(3'd3, 16'h0000);
    wr(3'd1, 16'h0010); wr(3'd2, 16'h0020);
    wr(3'd4, 16'h0007);
    #1 check("R8 no pending irq", {15'd0, irq}, 16'd0);
    wr(3'd0, 16'h0010); ticks(1);
    #1 check("R8 irq on A", {15'd0, irq}, 16'd1);
    check("R9 vec A", {11'd0, irq_vec}, 16'd16);
    wr(3'd0, 16'h0020); ticks(1);
    #1 check("R9 vec B over A", {11'd0, irq_vec}, 16'd17);
    wr(3'd0, 16'hFFFF); ticks(1);
    #1 check("R9 vec wrap over B", {11'd0, irq_vec}, 16'd18);
    wr(3'd4, 16'h0001);
    #1 check("R8 only A enabled vec", {11'd0, irq_vec}, 16'd16);
    wr(3'd4, 16'h0002);
    #1 check("R8 only B enabled vec", {11'd0, irq_vec}, 16'd17);
    wr(3'd4, 16'h0000);
    #1 check("R8 disabled irq", {15'd0, irq}, 16'd0);
    check("R9 disabled vec", {11'd0, irq_vec}, 16'd0);
    wr(3'd4, 16'h0004); wr(3'd3, 16'h0003);
    #1 check("R8 wrap cleared irq", {15'd0, irq}, 16'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule